// File: doc/BRIEF.md
# Strap-Configured Serial Port with Hardware Handshake

This block is a full-duplex asynchronous serial port whose line speed is fixed by two strap pins at the moment reset is released. Three strap patterns pick a fixed speed. The fourth pattern hands both the speed and the character format to a parameter word supplied by the surrounding system. That word is normally loaded from non-volatile settings, and its customary power-on content selects 9600 baud, no parity and one stop bit. Once the straps and the parameter word have been captured, they are frozen until the next reset.

Characters move in and out over byte-wide valid/ready streams. The transmitter serialises each byte with a start bit, eight data bits, an optional even or odd parity bit and one or two stop bits. The receiver oversamples the line at sixteen times the bit rate. It hands each byte to a one-entry holding register, together with framing-error and parity-error flags. Hardware handshaking works in both directions: the active-low clear-to-send input gates the start of new transmit characters, and the active-low request-to-send output tells the far end whether the holding register has room.

Top module: `strap_uart`

## Requirements
- R1: The straps and the parameter word are captured on the first rising clock edge after `rstN` goes high. Later changes on `strapA`, `strapB` or any `prm*` input have no effect until the next reset.
- R2: With `strapA`=1 and `strapB`=1 the port runs at 921600 baud with no parity and one stop bit, whatever the parameter word holds.
- R3: With `strapA`=1 and `strapB`=0 the port runs at 115200 baud. Parity and stop-bit count come from the parameter word.
- R4: With `strapA`=0 and `strapB`=1 the port runs at 9600 baud. Parity and stop-bit count come from the parameter word.
- R5: With both straps low, `prmRate` selects the speed by index: 0=2400, 1=4800, 2=7200, 3=9600, 4=19200, 5=38400, 6=57600, 7=115200, 8=230400, 9=460800, 10=921600. Indices 11 to 15 fall back to 9600.
- R6: A transmitted character is a low start bit, then the data bits LSB first, then, if `prmParEn`=1, a parity bit equal to the XOR of the data bits XOR `prmParOdd`, then one high stop bit, or two if `prmStop2`=1. The idle line is high.
- R7: `txReady` is low while `ctsN` is high, so no new character starts. A character already on the line is finished even if `ctsN` rises during it.
- R8: `rtsN` is high while the receive holding register is full and low once it has been read. A character that completes while the register is full is discarded and the held byte is kept.
- R9: The receiver confirms a start bit half a bit time after the falling edge. A low pulse shorter than that produces no byte, and a well-formed character is presented on `rxData` with `rxValid`=1.
- R10: `rxFrameErr` is set with the byte when the first stop bit is sampled low. `rxParErr` is set when parity is enabled and the received parity bit differs from the expected value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapA | input | 1 | Speed strap, first pin |
| strapB | input | 1 | Speed strap, second pin |
| prmRate | input | 4 | Parameter word: speed index |
| prmParEn | input | 1 | Parameter word: parity enable |
| prmParOdd | input | 1 | Parameter word: 1 = odd parity, 0 = even |
| prmStop2 | input | 1 | Parameter word: 1 = two stop bits |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter accepts the byte this cycle |
| rxData | output | 8 | Received byte |
| rxFrameErr | output | 1 | Received byte had a low stop bit |
| rxParErr | output | 1 | Received byte had a parity mismatch |
| rxValid | output | 1 | Holding register full |
| rxReady | input | 1 | Consumer takes the held byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| ctsN | input | 1 | Active-low clear-to-send from the far end |
| rtsN | output | 1 | Active-low request-to-send to the far end |

## Verification
The assertions check four properties on every cycle: the captured configuration never moves after capture, a character never begins unless clear-to-send was low, every character opens with a low line, and a full holding register keeps its byte until it is read. Only the bench scenarios can show that each strap pattern produces the right bit period and format, because that needs the serial waveform sampled at mid-bit. The same holds for rejecting short start glitches, flagging framing and parity faults, and dropping a second byte while the holding register is full.

// File: rtl/strap_uart_pkg.sv
package strap_uart_pkg;

  localparam int unsigned IDX_W      = 4;
  localparam int unsigned IDX_LAST   = 10;
  localparam logic [3:0]  IDX_9600   = 4'd3;
  localparam logic [3:0]  IDX_115K   = 4'd7;
  localparam logic [3:0]  IDX_921K   = 4'd10;

  // Strobes and frozen format handed from control to datapath
  typedef struct packed {
    logic enable;   // configuration captured
    logic tick;     // 16x oversample tick
    logic txStart;  // load a new transmit character
    logic parEn;
    logic parOdd;
    logic stop2;
  } uartStrobe_t;

  function automatic int unsigned rateOf(input logic [3:0] idx);
    case (idx)
      4'd0:    return 2400;
      4'd1:    return 4800;
      4'd2:    return 7200;
      4'd3:    return 9600;
      4'd4:    return 19200;
      4'd5:    return 38400;
      4'd6:    return 57600;
      4'd7:    return 115200;
      4'd8:    return 230400;
      4'd9:    return 460800;
      4'd10:   return 921600;
      default: return 9600;
    endcase
  endfunction

endpackage

// File: rtl/strap_uart_ctrl.sv
module strap_uart_ctrl
  import strap_uart_pkg::*;
#(
  parameter int unsigned CLK_HZ = 58982400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapA,
  input  logic        strapB,
  input  logic [3:0]  prmRate,
  input  logic        prmParEn,
  input  logic        prmParOdd,
  input  logic        prmStop2,
  input  logic        txValid,
  input  logic        ctsN,
  input  logic        txBusy,
  output logic        txReady,
  output uartStrobe_t strobe
);

  localparam int unsigned MAX_DIV = (CLK_HZ + 19200) / 38400;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 2);

  function automatic logic [DIV_W-1:0] divFor(input logic [3:0] idx);
    int unsigned r;
    int unsigned q;
    r = rateOf(idx);
    q = (CLK_HZ + r * 8) / (r * 16);
    if (q == 0) q = 1;
    return DIV_W'(q);
  endfunction

  logic             cfgDone;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] baudCnt;
  logic             parEnR, parOddR, stop2R;
  logic [3:0]       idxSel;
  logic             fmtFromPrm;
  logic             baudWrap;

  // Strap decode: both low hands the choice to the parameter word
  always_comb begin
    fmtFromPrm = !(strapA && strapB);
    case ({strapA, strapB})
      2'b11:   idxSel = IDX_921K;
      2'b10:   idxSel = IDX_115K;
      2'b01:   idxSel = IDX_9600;
      default: idxSel = (prmRate > 4'(IDX_LAST)) ? IDX_9600 : prmRate;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDone <= 1'b0;
      divReg  <= DIV_W'(1);
      parEnR  <= 1'b0;
      parOddR <= 1'b0;
      stop2R  <= 1'b0;
    end else if (!cfgDone) begin
      cfgDone <= 1'b1;
      divReg  <= divFor(idxSel);
      parEnR  <= fmtFromPrm && prmParEn;
      parOddR <= fmtFromPrm && prmParOdd;
      stop2R  <= fmtFromPrm && prmStop2;
    end
  end

  assign baudWrap = (baudCnt >= divReg - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          baudCnt <= '0;
    else if (!cfgDone)  baudCnt <= '0;
    else if (baudWrap)  baudCnt <= '0;
    else                baudCnt <= baudCnt + DIV_W'(1);
  end

  assign txReady = cfgDone && !ctsN && !txBusy;

  always_comb begin
    strobe.enable  = cfgDone;
    strobe.tick    = cfgDone && baudWrap;
    strobe.txStart = txReady && txValid;
    strobe.parEn   = parEnR;
    strobe.parOdd  = parOddR;
    strobe.stop2   = stop2R;
  end

  // R1: captured configuration stays put
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> $stable(divReg) && $stable({parEnR, parOddR, stop2R}));

  // R7: a character only begins after clear-to-send was low
  a_r7_start_needs_cts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(!ctsN));

endmodule

// File: rtl/strap_uart_dp.sv
module strap_uart_dp
  import strap_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  uartStrobe_t strobe,
  input  logic [7:0]  txData,
  output logic        txBusy,
  output logic        txd,
  input  logic        rxd,
  output logic [7:0]  rxData,
  output logic        rxFrameErr,
  output logic        rxParErr,
  output logic        rxValid,
  input  logic        rxReady,
  output logic        rtsN
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

  // ---------------- transmit ----------------
  logic [11:0] txShift;
  logic [11:0] txFrame;
  logic [3:0]  txLeft;
  logic [3:0]  txSub;

  assign txFrame = {2'b11,
                    strobe.parEn ? (^txData ^ strobe.parOdd) : 1'b1,
                    txData, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txLeft  <= '0;
      txSub   <= '0;
    end else if (strobe.txStart) begin
      txBusy  <= 1'b1;
      txShift <= txFrame;
      txLeft  <= 4'd10 + {3'b0, strobe.parEn} + {3'b0, strobe.stop2};
      txSub   <= '0;
    end else if (txBusy && strobe.tick) begin
      txSub <= txSub + 4'd1;
      if (txSub == 4'd15) begin
        txShift <= {1'b1, txShift[11:1]};
        txLeft  <= txLeft - 4'd1;
        if (txLeft == 4'd1) txBusy <= 1'b0;
      end
    end
  end

  assign txd = txBusy ? txShift[0] : 1'b1;

  // ---------------- receive ----------------
  rxState_t   rxState;
  logic       rxMeta, rxs;
  logic [3:0] rxSub, rxIdx, stopIdx;
  logic [7:0] rxShift;
  logic       parAcc, parBad;

  assign stopIdx = strobe.parEn ? 4'd9 : 4'd8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta     <= 1'b1;
      rxs        <= 1'b1;
      rxState    <= RX_IDLE;
      rxSub      <= '0;
      rxIdx      <= '0;
      rxShift    <= '0;
      parAcc     <= 1'b0;
      parBad     <= 1'b0;
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxFrameErr <= 1'b0;
      rxParErr   <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxs    <= rxMeta;
      if (rxValid && rxReady) rxValid <= 1'b0;
      if (strobe.tick) begin
        case (rxState)
          RX_IDLE: if (!rxs) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
          RX_START: begin
            rxSub <= rxSub + 4'd1;
            if (rxSub == 4'd7) begin
              if (!rxs) begin
                rxState <= RX_BITS;
                rxSub   <= '0;
                rxIdx   <= '0;
                parAcc  <= 1'b0;
                parBad  <= 1'b0;
              end else begin
                rxState <= RX_IDLE;
              end
            end
          end
          RX_BITS: begin
            rxSub <= rxSub + 4'd1;
            if (rxSub == 4'd15) begin
              rxIdx <= rxIdx + 4'd1;
              if (rxIdx < 4'd8) begin
                rxShift <= {rxs, rxShift[7:1]};
                parAcc  <= parAcc ^ rxs;
              end else if (rxIdx == stopIdx) begin
                rxState <= RX_IDLE;
                if (!rxValid) begin
                  rxValid    <= 1'b1;
                  rxData     <= rxShift;
                  rxFrameErr <= !rxs;
                  rxParErr   <= parBad;
                end
              end else begin
                parBad <= rxs ^ parAcc ^ strobe.parOdd;
              end
            end
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  assign rtsN = rxValid;

  // R6: every character opens with a low start bit
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txd);

  // R8: an unread byte is never overwritten
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid && $stable(rxData));

endmodule

// File: rtl/strap_uart.sv
module strap_uart
  import strap_uart_pkg::*;
#(
  parameter int unsigned CLK_HZ = 58982400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapA,
  input  logic       strapB,
  input  logic [3:0] prmRate,
  input  logic       prmParEn,
  input  logic       prmParOdd,
  input  logic       prmStop2,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxFrameErr,
  output logic       rxParErr,
  output logic       rxValid,
  input  logic       rxReady,
  output logic       txd,
  input  logic       rxd,
  input  logic       ctsN,
  output logic       rtsN
);

  uartStrobe_t strobe;
  logic        txBusy;

  strap_uart_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapA(strapA), .strapB(strapB),
    .prmRate(prmRate), .prmParEn(prmParEn), .prmParOdd(prmParOdd),
    .prmStop2(prmStop2), .txValid(txValid), .ctsN(ctsN),
    .txBusy(txBusy), .txReady(txReady), .strobe(strobe)
  );

  strap_uart_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .txBusy(txBusy), .txd(txd), .rxd(rxd), .rxData(rxData),
    .rxFrameErr(rxFrameErr), .rxParErr(rxParErr), .rxValid(rxValid),
    .rxReady(rxReady), .rtsN(rtsN)
  );

endmodule

// File: tb/strap_uart_bench.sv
module strap_uart_bench;

  localparam int unsigned HZ = 29491200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapA = 1'b1, strapB = 1'b1;
  logic [3:0] prmRate = 4'd3;
  logic       prmParEn = 1'b0, prmParOdd = 1'b0, prmStop2 = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxFrameErr, rxParErr, rxValid;
  logic       rxReady = 1'b0;
  logic       txd;
  logic       rxd = 1'b1;
  logic       ctsN = 1'b0;
  logic       rtsN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  strap_uart #(.CLK_HZ(HZ)) u_strap_uart (
    .clk(clk), .rstN(rstN), .strapA(strapA), .strapB(strapB),
    .prmRate(prmRate), .prmParEn(prmParEn), .prmParOdd(prmParOdd),
    .prmStop2(prmStop2), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxFrameErr(rxFrameErr),
    .rxParErr(rxParErr), .rxValid(rxValid), .rxReady(rxReady),
    .txd(txd), .rxd(rxd), .ctsN(ctsN), .rtsN(rtsN)
  );

  function automatic int bitClk(input int rate);
    return HZ / rate;
  endfunction

  function automatic logic [11:0] frameOf(input logic [7:0] d, input bit pe,
                                          input bit po, input bit badPar,
                                          input bit badStop);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (pe) f[9] = (^d) ^ po ^ badPar;
    f[pe ? 10 : 9] = !badStop;
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reset with the given straps and parameter word, then scramble them (R1)
  task automatic doReset(input bit a, input bit b, input logic [3:0] idx,
                         input bit pe, input bit po, input bit s2);
    @(negedge clk);
    rstN = 1'b0;
    strapA = a; strapB = b; prmRate = idx;
    prmParEn = pe; prmParOdd = po; prmStop2 = s2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strapA = ~a; strapB = ~b; prmRate = ~idx;
    prmParEn = ~pe; prmParOdd = ~po; prmStop2 = ~s2;
    repeat (4) @(negedge clk);
  endtask

  task automatic txFrame(input logic [7:0] d, input int bc, input bit pe,
                         input bit po, input bit s2, input bit dropCts,
                         input string tag);
    logic [11:0] f;
    int n;
    f = frameOf(d, pe, po, 1'b0, 1'b0);
    n = 10 + int'(pe) + int'(s2);
    @(negedge clk);
    txData = d;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    if (dropCts) ctsN = 1'b1;
    for (int k = 0; k < n; k++) begin
      repeat ((k == 0) ? bc / 2 : bc) @(negedge clk);
      chk(txd == f[k], tag, int'(txd), int'(f[k]));
    end
    chk(txReady == 1'b0, {tag, " busy in last stop"}, int'(txReady), 0);
    repeat (bc) @(negedge clk);
    chk(txReady == !dropCts && txd == 1'b1, {tag, " after frame"},
        int'({txReady, txd}), int'({!dropCts, 1'b1}));
  endtask

  task automatic rxDrive(input logic [7:0] d, input int bc, input bit pe,
                         input bit po, input bit s2, input bit badPar,
                         input bit badStop);
    logic [11:0] f;
    int n;
    f = frameOf(d, pe, po, badPar, badStop);
    n = 10 + int'(pe) + int'(s2);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxd = f[k];
      repeat (bc - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic rxPop();
    @(negedge clk);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic rxFrame(input logic [7:0] d, input int bc, input bit pe,
                         input bit po, input bit s2, input bit badPar,
                         input bit badStop, input string tag);
    rxDrive(d, bc, pe, po, s2, badPar, badStop);
    repeat (4) @(negedge clk);
    chk(rxValid && rxData == d, tag, int'({rxValid, rxData}), int'({1'b1, d}));
    chk(rxParErr == (pe && badPar) && rxFrameErr == badStop, {tag, " flags"},
        int'({rxParErr, rxFrameErr}), int'({pe && badPar, badStop}));
    if (badStop) repeat (2 * bc) @(negedge clk);
    rxPop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    logic [7:0] d;
    bit pe, po, s2;
    void'($urandom(32'd2024));

    // Reset state (R6 idle line, R8 room to receive)
    repeat (2) @(negedge clk);
    chk(txd == 1'b1 && rtsN == 1'b0 && rxValid == 1'b0 && txReady == 1'b0,
        "R6 R8 reset state", int'({txd, rtsN, rxValid, txReady}), 4'b1000);

    // R2 + R1: fast straps, parameter word asks for parity/2 stops and is ignored
    doReset(1'b1, 1'b1, 4'd5, 1'b1, 1'b1, 1'b1);
    b = bitClk(921600);
    txFrame(8'hA5, b, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R1 tx 921k6 8N1");
    rxFrame(8'h3C, b, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 R2 rx 921k6");
    for (int i = 0; i < 6; i++) begin
      d = 8'($urandom);
      txFrame(d, b, 1'b0, 1'b0, 1'b0, 1'b0, "R6 random tx");
      d = 8'($urandom);
      rxFrame(d, b, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 random rx");
    end

    // R7: clear-to-send high blocks a new character
    @(negedge clk);
    ctsN = 1'b1;
    txData = 8'h81;
    txValid = 1'b1;
    repeat (100) @(negedge clk);
    chk(txReady == 1'b0 && txd == 1'b1, "R7 blocked by cts",
        int'({txReady, txd}), 2'b01);
    txValid = 1'b0;
    ctsN = 1'b0;
    // R7: cts rising mid-character lets it finish, next one waits
    txFrame(8'h6E, b, 1'b0, 1'b0, 1'b0, 1'b1, "R7 finish after cts drop");
    repeat (3 * b) @(negedge clk);
    chk(txd == 1'b1, "R7 no new start", int'(txd), 1);
    ctsN = 1'b0;

    // R8: full holding register raises rtsN, extra byte dropped
    rxDrive(8'h11, b, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(rtsN == 1'b1, "R8 rts high when full", int'(rtsN), 1);
    rxDrive(8'h22, b, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(rxValid && rxData == 8'h11, "R8 held byte kept", int'(rxData), 8'h11);
    rxPop();
    repeat (2) @(negedge clk);
    chk(rtsN == 1'b0 && rxValid == 1'b0, "R8 drained, dropped byte gone",
        int'({rtsN, rxValid}), 0);

    // R9: a glitch shorter than half a bit yields nothing
    @(negedge clk);
    rxd = 1'b0;
    repeat (b / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * b) @(negedge clk);
    chk(rxValid == 1'b0, "R9 glitch rejected", int'(rxValid), 0);

    // R3: 115200, even parity, two stop bits from the parameter word
    doReset(1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1);
    b = bitClk(115200);
    txFrame(8'h5A, b, 1'b1, 1'b0, 1'b1, 1'b0, "R3 tx 115k2 8E2");
    rxFrame(8'hC3, b, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 rx good");
    rxFrame(8'h07, b, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R10 parity error");
    rxFrame(8'hF0, b, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10 framing error");

    // R5: parameter-selected speeds with random formats
    for (int r = 0; r < 3; r++) begin
      pe = 1'($urandom); po = 1'($urandom); s2 = 1'($urandom);
      doReset(1'b0, 1'b0, 4'd9, pe, po, s2);
      b = bitClk(460800);
      for (int i = 0; i < 2; i++) begin
        d = 8'($urandom);
        txFrame(d, b, pe, po, s2, 1'b0, "R5 R6 tx idx9");
        d = 8'($urandom);
        rxFrame(d, b, pe, po, s2, 1'b0, 1'b0, "R5 R10 rx idx9");
      end
    end
    doReset(1'b0, 1'b0, 4'd8, 1'b1, 1'b1, 1'b0);
    txFrame(8'h96, bitClk(230400), 1'b1, 1'b1, 1'b0, 1'b0, "R5 tx idx8 8O1");

    // R5: out-of-range index falls back to 9600
    doReset(1'b0, 1'b0, 4'd13, 1'b0, 1'b0, 1'b0);
    txFrame(8'h4B, bitClk(9600), 1'b0, 1'b0, 1'b0, 1'b0, "R5 idx13 -> 9600");

    // R4: 9600 with odd parity from the parameter word
    doReset(1'b0, 1'b1, 4'd10, 1'b1, 1'b1, 1'b0);
    txFrame(8'h2D, bitClk(9600), 1'b1, 1'b1, 1'b0, 1'b0, "R4 tx 9600 8O1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule